// File: doc/BRIEF.md
# Station-Address PROM I/O Window Decoder

This block sits at the front of a network controller's host I/O window. It turns each host access, which arrives as an address, a byte count, write data and a read or write strobe, into one of three outcomes. It can serve the access from a small on-chip station-address PROM, hand it to the controller's register port, or reject it. A rejected read returns all ones and a rejected write changes nothing.

The PROM occupies the lowest offsets of the window. Which access widths and alignments the PROM accepts depends on a word/dword I/O mode input. Multi-byte PROM accesses are split into bytes, or assembled from bytes, in little-endian lane order. PROM writes need a separate write-enable input. At reset the PROM is loaded with a MAC address given as a parameter.

Accesses above the PROM are passed to the register port in the same cycle as the strobe. The data returned by the register port is captured. Every read answers one cycle after its strobe.

Top module: `prom_io_decoder`

## Requirements
- R1: After reset, `rd_valid` and `rd_data` are zero. PROM byte i holds bits 8i+7:8i of `MAC_ADDR` for i = 0..5, and bytes 6..15 hold zero.
- R2: An offset below 16 selects the PROM, with the byte picked by `acc_addr[3:0]`. Every offset of 16 or more belongs to the register port.
- R3: `acc_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. Code 3 is reserved and is never a legal access anywhere in the window.
- R4: With `dword_mode` low, a 1-byte PROM access is legal at any offset and a 2-byte PROM access is legal only at an even offset. A 4-byte PROM access is illegal.
- R5: With `dword_mode` high, the only legal PROM access is 4 bytes at an offset that is a multiple of 4.
- R6: A multi-byte PROM access is little-endian. The byte at the access offset uses data bits 7:0, and each higher offset uses the next byte lane up. A 1-byte or 2-byte PROM read is zero-extended to 32 bits.
- R7: A legal PROM write stores its bytes only when `prom_wr_en` is high in the strobe cycle. When `prom_wr_en` is low the write is dropped, and later reads still return the stored bytes.
- R8: At offsets of 16 or more, 2-byte and 4-byte accesses raise `fwd_valid` combinationally in the strobe cycle. `fwd_addr`, `fwd_size` and `fwd_wdata` carry the access unchanged, and `fwd_write` is set for writes. A forwarded read returns `fwd_rdata` masked to the access width. A 1-byte access there raises no `fwd_valid`.
- R9: A read that matches no legal case returns all ones over its width: 0x000000FF for 1 byte, 0x0000FFFF for 2 bytes, and 0xFFFFFFFF for 4 bytes or the reserved code.
- R10: A write that matches no legal case changes no PROM byte.
- R11: A read strobe produces `rd_valid` high with its data on the next cycle. In any cycle that follows no read strobe, `rd_valid` is low and `rd_data` keeps its last value.
- R12: When read and write strobes are both high for a legal PROM access, the write is applied and the read returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_addr | input | ADDR_W | Byte offset inside the I/O window |
| acc_size | input | 2 | Access size code (0:1B, 1:2B, 2:4B, 3:reserved) |
| acc_wdata | input | 32 | Write data, little-endian lanes |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| dword_mode | input | 1 | High selects dword I/O mode, low selects word I/O mode |
| prom_wr_en | input | 1 | Enables writes into the PROM |
| fwd_rdata | input | 32 | Read data from the register port, valid in the strobe cycle |
| rd_valid | output | 1 | Read response valid, one cycle after the read strobe |
| rd_data | output | 32 | Read response data |
| fwd_valid | output | 1 | Access forwarded to the register port |
| fwd_write | output | 1 | Forwarded access is a write |
| fwd_addr | output | ADDR_W | Forwarded offset |
| fwd_size | output | 2 | Forwarded size code |
| fwd_wdata | output | 32 | Forwarded write data |

## Verification
The read path and the PROM write path can act in the same cycle when both strobes are raised together on one PROM byte. The bench does this with a fresh byte value and the write enable set. It expects the registered response to show the old byte and a following read to show the new one. The sweep also places a write directly before a read of the same offset, for every offset, size and mode. This exposes any response that wrongly picks up bytes written one cycle earlier, or misses them.

// File: rtl/prom_io_pkg.sv
package prom_io_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        ROUTE_NONE = 2'd0,
        ROUTE_PROM = 2'd1,
        ROUTE_FWD  = 2'd2
    } route_e;

    function automatic logic [LANES-1:0] lanes_of(acc_size_e s);
        case (s)
            SZ_BYTE: lanes_of = LANES'(4'b0001);
            SZ_HALF: lanes_of = LANES'(4'b0011);
            SZ_WORD: lanes_of = LANES'(4'b1111);
            default: lanes_of = '0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] ones_of(acc_size_e s);
        case (s)
            SZ_BYTE: ones_of = DATA_W'(32'h0000_00FF);
            SZ_HALF: ones_of = DATA_W'(32'h0000_FFFF);
            default: ones_of = {DATA_W{1'b1}};
        endcase
    endfunction

endpackage

// File: rtl/prom_access_decode.sv
module prom_access_decode
    import prom_io_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int PROM_BYTES = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              dword_mode,
    output route_e            route,
    output logic [LANES-1:0]  lane_en,
    output logic [DATA_W-1:0] width_mask
);

    acc_size_e sz;
    logic      in_prom;
    logic      prom_ok;
    logic      fwd_ok;

    always_comb begin
        sz      = acc_size_e'(size);
        in_prom = (32'(addr) < PROM_BYTES);

        if (dword_mode) begin
            prom_ok = (sz == SZ_WORD) && (addr[1:0] == 2'b00);
        end else begin
            prom_ok = (sz == SZ_BYTE) || ((sz == SZ_HALF) && !addr[0]);
        end

        fwd_ok = (sz == SZ_HALF) || (sz == SZ_WORD);

        if (in_prom && prom_ok) begin
            route = ROUTE_PROM;
        end else if (!in_prom && fwd_ok) begin
            route = ROUTE_FWD;
        end else begin
            route = ROUTE_NONE;
        end

        lane_en    = (route == ROUTE_PROM) ? lanes_of(sz) : '0;
        width_mask = ones_of(sz);
    end

endmodule

// File: rtl/prom_byte_store.sv
module prom_byte_store
    import prom_io_pkg::*;
#(
    parameter int          PROM_BYTES = 16,
    parameter logic [47:0] MAC_ADDR   = 48'h0,
    localparam int         IDX_W      = $clog2(PROM_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_go,
    input  logic [IDX_W-1:0]        base,
    input  logic [LANES-1:0]        lane_en,
    input  logic [DATA_W-1:0]       wdata,
    output logic [PROM_BYTES*8-1:0] image
);

    localparam logic [PROM_BYTES*8-1:0] RESET_IMG = (PROM_BYTES*8)'(MAC_ADDR);

    typedef struct packed {
        logic [PROM_BYTES-1:0][7:0] mem;
    } store_t;

    store_t store_d, store_q;

    always_comb begin
        store_d = store_q;
        for (int i = 0; i < PROM_BYTES; i++) begin
            for (int l = 0; l < LANES; l++) begin
                if (wr_go && lane_en[l] &&
                    (IDX_W'(base + IDX_W'(l)) == IDX_W'(i))) begin
                    store_d.mem[i] = wdata[8*l +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q.mem <= RESET_IMG;
        end else begin
            store_q <= store_d;
        end
    end

    assign image = store_q.mem;

endmodule

// File: rtl/prom_read_mux.sv
module prom_read_mux
    import prom_io_pkg::*;
#(
    parameter int  PROM_BYTES = 16,
    localparam int IDX_W      = $clog2(PROM_BYTES)
) (
    input  logic [PROM_BYTES*8-1:0] image,
    input  logic [IDX_W-1:0]        base,
    input  logic [LANES-1:0]        lane_en,
    output logic [DATA_W-1:0]       rdata
);

    logic [IDX_W-1:0] idx [LANES];

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign idx[l] = IDX_W'(base + IDX_W'(l));
            assign rdata[8*l +: 8] = lane_en[l] ? image[8*idx[l] +: 8] : 8'h00;
        end
    endgenerate

endmodule

// File: rtl/prom_io_decoder.sv
module prom_io_decoder
    import prom_io_pkg::*;
#(
    parameter int          ADDR_W     = 5,
    parameter int          PROM_BYTES = 16,
    parameter logic [47:0] MAC_ADDR   = 48'h0000_0000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic [31:0]       acc_wdata,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic              dword_mode,
    input  logic              prom_wr_en,
    input  logic [31:0]       fwd_rdata,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic              fwd_valid,
    output logic              fwd_write,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic [1:0]        fwd_size,
    output logic [31:0]       fwd_wdata
);

    localparam int IDX_W = $clog2(PROM_BYTES);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } resp_t;

    route_e                  route;
    logic [LANES-1:0]        lane_en;
    logic [DATA_W-1:0]       width_mask;
    logic [PROM_BYTES*8-1:0] prom_image;
    logic [DATA_W-1:0]       prom_rdata;
    logic [IDX_W-1:0]        base;
    logic                    wr_go;
    resp_t                   resp_d, resp_q;

    assign base  = acc_addr[IDX_W-1:0];
    assign wr_go = acc_wr && prom_wr_en && (route == ROUTE_PROM);

    prom_access_decode #(
        .ADDR_W     (ADDR_W),
        .PROM_BYTES (PROM_BYTES)
    ) u_decode (
        .addr       (acc_addr),
        .size       (acc_size),
        .dword_mode (dword_mode),
        .route      (route),
        .lane_en    (lane_en),
        .width_mask (width_mask)
    );

    prom_byte_store #(
        .PROM_BYTES (PROM_BYTES),
        .MAC_ADDR   (MAC_ADDR)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_go   (wr_go),
        .base    (base),
        .lane_en (lane_en),
        .wdata   (acc_wdata),
        .image   (prom_image)
    );

    prom_read_mux #(
        .PROM_BYTES (PROM_BYTES)
    ) u_rmux (
        .image   (prom_image),
        .base    (base),
        .lane_en (lane_en),
        .rdata   (prom_rdata)
    );

    always_comb begin
        resp_d       = resp_q;
        resp_d.valid = acc_rd;
        if (acc_rd) begin
            case (route)
                ROUTE_PROM: resp_d.data = prom_rdata;
                ROUTE_FWD:  resp_d.data = fwd_rdata & width_mask;
                default:    resp_d.data = width_mask;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign rd_valid  = resp_q.valid;
    assign rd_data   = resp_q.data;
    assign fwd_valid = (acc_rd || acc_wr) && (route == ROUTE_FWD);
    assign fwd_write = acc_wr;
    assign fwd_addr  = acc_addr;
    assign fwd_size  = acc_size;
    assign fwd_wdata = acc_wdata;

endmodule

// File: rtl/prom_io_checker.sv
module prom_io_checker #(
    parameter int ADDR_W     = 5,
    parameter int PROM_BYTES = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [ADDR_W-1:0]       acc_addr,
    input logic [1:0]              acc_size,
    input logic                    acc_rd,
    input logic                    acc_wr,
    input logic                    dword_mode,
    input logic                    prom_wr_en,
    input logic                    rd_valid,
    input logic [31:0]             rd_data,
    input logic                    fwd_valid,
    input logic [PROM_BYTES*8-1:0] prom_image
);

    AST_FWD_ONLY_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> (32'(acc_addr) >= PROM_BYTES) &&
                      (acc_size == 2'd1 || acc_size == 2'd2)); // R8

    AST_RESP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd |=> rd_valid); // R11

    AST_NO_RESP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_rd |=> (!rd_valid && $stable(rd_data))); // R11

    AST_WE_LOW_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && !prom_wr_en) |=> $stable(prom_image)); // R7

    AST_DWORD_NARROW_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && dword_mode && acc_size != 2'd2) |=> $stable(prom_image)); // R10

    AST_UPPER_BYTE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && 32'(acc_addr) >= PROM_BYTES && acc_size == 2'd0)
            |=> (rd_data == 32'h0000_00FF)); // R9

endmodule

bind prom_io_decoder prom_io_checker #(
    .ADDR_W     (ADDR_W),
    .PROM_BYTES (PROM_BYTES)
) u_chk (.*);

// File: tb/prom_io_decoder_test.sv
module prom_io_decoder_test;

    localparam int          AW  = 5;
    localparam int          NB  = 16;
    localparam logic [47:0] MAC = 48'h5E4D_3C2B_1A00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic        acc_rd = 1'b0;
    logic        acc_wr = 1'b0;
    logic        dword_mode = 1'b0;
    logic        prom_wr_en = 1'b0;
    logic [31:0] fwd_rdata;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        fwd_valid;
    logic        fwd_write;
    logic [AW-1:0] fwd_addr;
    logic [1:0]  fwd_size;
    logic [31:0] fwd_wdata;

    int          n_chk = 0;
    int          n_err = 0;
    logic [7:0]  model [NB];
    logic [31:0] last_rd = '0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    assign fwd_rdata = 32'h9A3C_5E00 ^ {27'b0, acc_addr};

    prom_io_decoder #(.ADDR_W(AW), .PROM_BYTES(NB), .MAC_ADDR(MAC)) uut (.*);

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic int kind_of(int a, int s, bit m);
        if (a < NB) begin
            if (s == 3) return 0;
            if (m) return (s == 2 && a % 4 == 0) ? 1 : 0;
            return (s == 0 || (s == 1 && a % 2 == 0)) ? 1 : 0;
        end
        return (s == 1 || s == 2) ? 2 : 0;
    endfunction

    function automatic int nbytes(int s);
        return (s == 0) ? 1 : (s == 1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] mask_of(int s);
        return (s == 0) ? 32'hFF : (s == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] exp_rd(int a, int s, bit m);
        logic [31:0] v = '0;
        int k = kind_of(a, s, m);
        if (k == 1) begin
            for (int l = 0; l < nbytes(s); l++) v[8*l +: 8] = model[a + l];
            return v;
        end
        if (k == 2) return (32'h9A3C_5E00 ^ 32'(a)) & mask_of(s);
        return mask_of(s);
    endfunction

    function automatic string rd_tag(int a, int s, bit m);
        int k = kind_of(a, s, m);
        if (k == 1) return m ? "R5/R6" : "R2/R4/R6";
        if (k == 2) return "R2/R8";
        return (s == 3) ? "R3/R9" : "R9";
    endfunction

    task automatic do_acc(bit rd, bit wr, int a, int s, logic [31:0] wd, bit m, bit we);
        logic [31:0] e;
        int k;
        @(negedge clk);
        acc_rd = rd; acc_wr = wr; acc_addr = AW'(a); acc_size = 2'(s);
        acc_wdata = wd; dword_mode = m; prom_wr_en = we;
        #1;
        k = kind_of(a, s, m);
        chk(fwd_valid == ((rd || wr) && k == 2), "R8 fwd_valid", 32'(fwd_valid), 32'((rd || wr) && k == 2));
        if (k == 2) begin
            chk(fwd_addr == AW'(a) && fwd_size == 2'(s) && fwd_wdata == wd && fwd_write == wr,
                "R8 fwd fields", {fwd_addr, fwd_size, fwd_write, 24'b0}, {AW'(a), 2'(s), wr, 24'b0});
        end
        e = exp_rd(a, s, m);
        @(posedge clk);
        #1;
        acc_rd = 1'b0; acc_wr = 1'b0;
        if (rd) begin
            chk(rd_valid == 1'b1, "R11 rd_valid", 32'(rd_valid), 32'd1);
            chk(rd_data == e, rd_tag(a, s, m), rd_data, e);
            last_rd = rd_data;
        end else begin
            chk(rd_valid == 1'b0 && rd_data == last_rd, "R11 hold", rd_data, last_rd);
        end
        if (wr && k == 1 && we) begin
            for (int l = 0; l < nbytes(s); l++) model[a + l] = wd[8*l +: 8];
        end
    endtask

    task automatic dump(string tag);
        for (int a = 0; a < NB; a++) begin
            do_acc(1'b1, 1'b0, a, 0, 32'h0, 1'b0, 1'b0);
            chk(rd_data == {24'b0, model[a]}, tag, rd_data, {24'b0, model[a]});
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NB; i++) model[i] = (i < 6) ? MAC[8*i +: 8] : 8'h00;
        repeat (3) @(posedge clk);
        #1;
        chk(rd_valid == 1'b0 && rd_data == 32'h0, "R1 reset outputs", rd_data, 32'h0);
        rst_n = 1'b1;
        dump("R1 reset image");

        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                for (int a = 0; a < 2 * NB; a++) begin
                    logic [31:0] wd = 32'h1357_9BDF * 32'(a + 1) + 32'(s) + 32'(m * 256);
                    bit we = (a % 3 != 1);
                    do_acc(1'b0, 1'b1, a, s, wd, m[0], we);
                    do_acc(1'b1, 1'b0, a, s, 32'h0, m[0], 1'b0);
                end
                dump("R7/R10 image");
            end
        end

        // R12: read and write of the same PROM byte in one cycle
        do_acc(1'b1, 1'b1, 3, 0, 32'h0000_00A7, 1'b0, 1'b1);
        do_acc(1'b1, 1'b0, 3, 0, 32'h0, 1'b0, 1'b0);
        chk(rd_data == 32'hA7, "R12 write landed", rd_data, 32'hA7);
        do_acc(1'b1, 1'b1, 8, 2, 32'hC1C2_C3C4, 1'b1, 1'b1);
        do_acc(1'b1, 1'b0, 8, 2, 32'h0, 1'b1, 1'b0);
        chk(rd_data == 32'hC1C2_C3C4, "R12 dword landed", rd_data, 32'hC1C2_C3C4);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule